// File: doc/BRIEF.md
# Buffered SPI Status and Data Buffer Unit

This block sits between a CPU register port and the serial shift engine of an SPI peripheral that runs with buffering. For transmission it keeps one holding byte. The engine takes that byte with a load pulse and reports the end of each shift with a done pulse. For reception it keeps a two-entry first-in first-out buffer, which the engine fills with a receive pulse. The CPU writes and reads the data port, and it reads the five status flags through a flag port whose written ones clear flags.

Flags also change as side effects of data-port traffic. A data write clears the transmit-empty flag. A data read can clear the receive-complete flag and the overflow flag. An overflow happens when the receive buffer is full and one more byte completes. If the holding buffer is empty at that moment, the overflow report waits for the next transfer start. A falling edge on the external slave-select pin while in master mode raises a flag and a one-cycle request to drop to slave mode. The disable input blocks this. Each flag has an enable bit at the same position, and the enabled flags are ORed into one registered interrupt line.

The transmit path is a four-state machine:
- `TX_IDLE`: buffer empty, shifter idle.
- `TX_LOADED`: buffer full, shifter idle.
- `TX_SHIFT`: buffer empty, shifter busy.
- `TX_SHIFT_QUEUED`: buffer full, shifter busy.

Its transitions are:
- A data write moves `TX_IDLE` to `TX_LOADED` and `TX_SHIFT` to `TX_SHIFT_QUEUED`.
- A load pulse moves `TX_LOADED` to `TX_SHIFT`, or to `TX_SHIFT_QUEUED` when a write comes in the same cycle.
- A done pulse moves `TX_SHIFT` to `TX_IDLE`, or to `TX_LOADED` when a write comes in the same cycle.
- A done pulse moves `TX_SHIFT_QUEUED` to `TX_LOADED`.
- A done pulse together with a load pulse moves `TX_SHIFT_QUEUED` to `TX_SHIFT`, or keeps it in `TX_SHIFT_QUEUED` when a write comes in the same cycle.

Top module: `spibuf_flag_unit`

## Requirements
- R1: After reset the flag port reads 8'h20, which is only the transmit-empty flag. The interrupt output is 0. Flag bits 3, 2 and 1 always read 0, even after ones are written to them.
- R2: A data write stores the byte in the holding buffer and clears the transmit-empty flag (bit 5) in the next cycle. A load pulse moves the byte to the shifter and sets bit 5 again. Writing a 1 to bit 5 has no effect.
- R3: The transfer-complete flag (bit 6) sets when a done pulse arrives and the holding buffer is empty. It does not set when a byte is waiting in the holding buffer. Only a written 1 at bit 6 clears it.
- R4: The receive buffer holds two bytes in arrival order. The data port shows the oldest byte, and a data read removes it. An empty buffer reads 8'h00.
- R5: The receive-complete flag (bit 7) sets on every receive pulse. It clears on the data read that empties the buffer, or on a written 1 at bit 7.
- R6: A receive pulse that finds the buffer full, with no data read in the same cycle, discards the new byte and keeps the stored ones. If the holding buffer has data, the overflow flag (bit 0) sets in the next cycle. A data read in the same cycle as the receive pulse frees a slot, so no overflow occurs.
- R7: If the holding buffer is empty when an overflow happens, bit 0 stays 0 until the next load pulse, and then it sets.
- R8: Any data read clears bit 0, and so does a written 1 at bit 0.
- R9: A falling edge on the slave-select pin sets the slave-select flag (bit 4) exactly once, three cycles after the pin changes. This happens only while master mode is on and slave-select-disable is 0. The force-slave output pulses for one cycle together with the flag. A written 1 at bit 4 clears the flag.
- R10: When a hardware set and a written 1 clear hit the same flag in the same cycle, the flag ends up set.
- R11: The interrupt output equals the OR over all bits of the flags ANDed with the enables, as they stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_wr | input | 1 | CPU writes the data port |
| data_wdata | input | DW | Byte written to the holding buffer |
| data_rd | input | 1 | CPU reads the data port (pops the receive buffer) |
| data_rdata | output | DW | Oldest received byte, 0 when empty |
| flag_wr | input | 1 | CPU writes the flag port |
| flag_wdata | input | 8 | Ones clear the flags at those positions |
| flag_rdata | output | 8 | Flag vector: 7 rx complete, 6 tx complete, 5 tx empty, 4 slave select, 0 overflow |
| irq_en | input | 8 | Per-flag interrupt enables, same bit positions |
| irq | output | 1 | Registered interrupt request |
| tx_data | output | DW | Holding buffer contents for the shifter |
| tx_load | input | 1 | Shifter took the holding byte (transfer start) |
| tx_done | input | 1 | Shifter finished a byte |
| rx_valid | input | 1 | Shifter completed a received byte |
| rx_byte | input | DW | Received byte |
| is_master | input | 1 | Unit is in master mode |
| ss_n_pin | input | 1 | Asynchronous external slave-select pin |
| ss_disable | input | 1 | Blocks slave-select detection |
| force_slave | output | 1 | One-cycle request to switch to slave mode |

## Verification
The bench builds the block with its default parameters: an 8-bit data width, a two-entry receive buffer and a two-stage synchronizer. With a buffer this shallow, a third received byte reaches the full and overflow cases, and the bench sweeps from one to three received bytes, both with and without transmit data pending. The 8-bit enable field is small enough to sweep all 256 patterns against two known flag states. The two-stage synchronizer gives an exact three-cycle latency, which the bench checks for the slave-select flag.

// File: rtl/spibuf_pkg.sv
package spibuf_pkg;
    localparam int FLAG_W  = 8;
    localparam int BIT_RXC = 7;
    localparam int BIT_TXC = 6;
    localparam int BIT_DRE = 5;
    localparam int BIT_SS  = 4;
    localparam int BIT_OVF = 0;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_LOADED,
        TX_SHIFT,
        TX_SHIFT_QUEUED
    } tx_state_t;
endpackage

// File: rtl/spibuf_rx_fifo.sv
module spibuf_rx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DW-1:0]                din,
    input  logic                         pop,
    output logic [DW-1:0]                dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R4
    AST_FULL_KEEPS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(dout))); // R6
endmodule

// File: rtl/spibuf_ss_edge.sv
module spibuf_ss_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= pin_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[STAGES-2:0], pin_n};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign fall = prev_q && !sync_q[STAGES-1];

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R9
endmodule

// File: rtl/spibuf_flag_unit.sv
module spibuf_flag_unit
    import spibuf_pkg::*;
#(
    parameter int DW        = 8,
    parameter int RX_DEPTH  = 2,
    parameter int SS_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_wr,
    input  logic [DW-1:0] data_wdata,
    input  logic          data_rd,
    output logic [DW-1:0] data_rdata,
    input  logic          flag_wr,
    input  logic [7:0]    flag_wdata,
    output logic [7:0]    flag_rdata,
    input  logic [7:0]    irq_en,
    output logic          irq,
    output logic [DW-1:0] tx_data,
    input  logic          tx_load,
    input  logic          tx_done,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          is_master,
    input  logic          ss_n_pin,
    input  logic          ss_disable,
    output logic          force_slave
);
    localparam int RX_CW = $clog2(RX_DEPTH+1);

    tx_state_t         state_q, state_d;
    logic [DW-1:0]     tx_buf_q;
    logic              rxc_q, txc_q, ss_q, ovf_q, ovf_pend_q, irq_q, force_q;
    logic              has_data, dre_flag;
    logic [RX_CW-1:0]  rx_count;
    logic              rx_full, rx_empty, rx_pop;
    logic              ss_fall;
    logic [7:0]        w1c;
    logic              txc_set, ss_set, ovf_evt, ovf_set, rxc_rd_clr;

    spibuf_rx_fifo #(.DW(DW), .DEPTH(RX_DEPTH)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .push(rx_valid), .din(rx_byte),
        .pop(data_rd), .dout(data_rdata), .count(rx_count),
        .full(rx_full), .empty(rx_empty)
    );

    spibuf_ss_edge #(.STAGES(SS_STAGES)) ss_edge_i (
        .clk(clk), .rst_n(rst_n), .pin_n(ss_n_pin), .fall(ss_fall)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:
                if (data_wr) state_d = TX_LOADED;
            TX_LOADED:
                if (tx_load) state_d = data_wr ? TX_SHIFT_QUEUED : TX_SHIFT;
            TX_SHIFT:
                if (tx_done)      state_d = data_wr ? TX_LOADED : TX_IDLE;
                else if (data_wr) state_d = TX_SHIFT_QUEUED;
            TX_SHIFT_QUEUED:
                if (tx_done && tx_load) state_d = data_wr ? TX_SHIFT_QUEUED : TX_SHIFT;
                else if (tx_done)       state_d = TX_LOADED;
            default: state_d = TX_IDLE;
        endcase
    end

    // outputs and flag events
    always_comb begin
        has_data   = (state_q == TX_LOADED) || (state_q == TX_SHIFT_QUEUED);
        dre_flag   = !has_data;
        w1c        = flag_wr ? flag_wdata : 8'h00;
        rx_pop     = data_rd && !rx_empty;
        txc_set    = (state_q == TX_SHIFT) && tx_done && !data_wr;
        ss_set     = ss_fall && is_master && !ss_disable;
        ovf_evt    = rx_valid && rx_full && !rx_pop;
        ovf_set    = (ovf_evt && has_data) || (ovf_pend_q && tx_load);
        rxc_rd_clr = rx_pop && (rx_count == RX_CW'(1));
        flag_rdata          = 8'h00;
        flag_rdata[BIT_RXC] = rxc_q;
        flag_rdata[BIT_TXC] = txc_q;
        flag_rdata[BIT_DRE] = dre_flag;
        flag_rdata[BIT_SS]  = ss_q;
        flag_rdata[BIT_OVF] = ovf_q;
        tx_data     = tx_buf_q;
        irq         = irq_q;
        force_slave = force_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tx_buf_q <= '0;
        else if (data_wr) tx_buf_q <= data_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxc_q      <= 1'b0;
            txc_q      <= 1'b0;
            ss_q       <= 1'b0;
            ovf_q      <= 1'b0;
            ovf_pend_q <= 1'b0;
            irq_q      <= 1'b0;
            force_q    <= 1'b0;
        end else begin
            if (rx_valid)                        rxc_q <= 1'b1;
            else if (w1c[BIT_RXC] || rxc_rd_clr) rxc_q <= 1'b0;

            if (txc_set)           txc_q <= 1'b1;
            else if (w1c[BIT_TXC]) txc_q <= 1'b0;

            if (ss_set)           ss_q <= 1'b1;
            else if (w1c[BIT_SS]) ss_q <= 1'b0;

            if (ovf_set)                      ovf_q <= 1'b1;
            else if (w1c[BIT_OVF] || data_rd) ovf_q <= 1'b0;

            if (ovf_evt && !has_data)       ovf_pend_q <= 1'b1;
            else if (ovf_pend_q && tx_load) ovf_pend_q <= 1'b0;

            irq_q   <= |(flag_rdata & irq_en);
            force_q <= ss_set;
        end
    end

    AST_WRITE_CLEARS_DRE: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> !flag_rdata[BIT_DRE]); // R2
    AST_TXC_ONLY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txc_q) |-> dre_flag); // R3
    AST_OVF_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !ovf_set) |=> !ovf_q); // R8
    AST_SS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ss_disable |=> !$rose(ss_q)); // R9
    AST_FORCE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        force_slave |=> !force_slave); // R9
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_rdata & irq_en) == 8'h00) |=> !irq); // R11
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rdata[3:1] == 3'b000); // R1
endmodule

// File: tb/spibuf_flag_unit_tb_top.sv
`timescale 1ns/1ps
module spibuf_flag_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_wr = 0, data_rd = 0, flag_wr = 0;
    logic [7:0] data_wdata = 0, flag_wdata = 0, irq_en = 0, rx_byte = 0;
    logic       tx_load = 0, tx_done = 0, rx_valid = 0;
    logic       is_master = 0, ss_n_pin = 1, ss_disable = 0;
    logic [7:0] data_rdata, flag_rdata, tx_data;
    logic       irq, force_slave;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    spibuf_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_wdata(data_wdata),
        .data_rd(data_rd), .data_rdata(data_rdata), .flag_wr(flag_wr),
        .flag_wdata(flag_wdata), .flag_rdata(flag_rdata), .irq_en(irq_en),
        .irq(irq), .tx_data(tx_data), .tx_load(tx_load), .tx_done(tx_done),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .is_master(is_master),
        .ss_n_pin(ss_n_pin), .ss_disable(ss_disable), .force_slave(force_slave)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        data_wr = 0; data_rd = 0; flag_wr = 0; tx_load = 0; tx_done = 0; rx_valid = 0;
    endtask

    task automatic wr_data(input logic [7:0] v);
        data_wr = 1; data_wdata = v; tick();
    endtask
    task automatic w1(input logic [7:0] v);
        flag_wr = 1; flag_wdata = v; tick();
    endtask
    task automatic rx(input logic [7:0] v);
        rx_valid = 1; rx_byte = v; tick();
    endtask
    task automatic rd();
        data_rd = 1; tick();
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 reset flags", flag_rdata, 8'h20);
        chk("R1 reset irq", {7'd0, irq}, 8'h00);
        chk("R4 empty read", data_rdata, 8'h00);
        w1(8'hFF);
        chk("R1 R2 unused bits and dre w1", flag_rdata, 8'h20);

        wr_data(8'h5A);
        chk("R2 dre cleared", flag_rdata, 8'h00);
        chk("R2 tx_data", tx_data, 8'h5A);
        tx_load = 1; tick();
        chk("R2 dre set on load", flag_rdata, 8'h20);
        tx_done = 1; tick();
        chk("R3 txc set", flag_rdata, 8'h60);
        w1(8'h20);
        chk("R3 txc kept by other w1", flag_rdata, 8'h60);
        w1(8'h40);
        chk("R3 txc w1 clear", flag_rdata, 8'h20);

        wr_data(8'h33); tx_load = 1; tick(); wr_data(8'h44);
        chk("R2 queued dre", flag_rdata, 8'h00);
        tx_done = 1; tick();
        chk("R3 no txc with waiting byte", flag_rdata, 8'h00);
        chk("R2 queued tx_data", tx_data, 8'h44);
        tx_load = 1; tick(); tx_done = 1; tick();
        chk("R3 txc after drain", flag_rdata, 8'h60);
        w1(8'h40);

        // receive sweep with transmit data pending
        wr_data(8'h77);
        for (int n = 1; n <= 3; n++) begin
            for (int i = 0; i < n; i++) rx(8'(16*n + i));
            chk("R5 R6 after fill", flag_rdata, (n == 3) ? 8'h81 : 8'h80);
            for (int i = 0; i < ((n > 2) ? 2 : n); i++) begin
                chk("R4 oldest byte", data_rdata, 8'(16*n + i));
                rd();
                if (n == 3 && i == 0) chk("R8 read clears ovf", flag_rdata, 8'h80);
            end
            chk("R5 rxc cleared on empty", flag_rdata, 8'h00);
            chk("R4 empty after reads", data_rdata, 8'h00);
        end

        rx(8'hA1); rx(8'hB1);
        data_rd = 1; rx_valid = 1; rx_byte = 8'hC1; tick();
        chk("R6 read frees slot no ovf", flag_rdata, 8'h80);
        chk("R4 order after simultaneous", data_rdata, 8'hB1);
        rd();
        chk("R6 simultaneous byte kept", data_rdata, 8'hC1);
        rd();

        rx_valid = 1; rx_byte = 8'hD0; flag_wr = 1; flag_wdata = 8'h80; tick();
        chk("R10 set wins over w1", flag_rdata, 8'h80);
        w1(8'h80);
        chk("R5 w1 clears rxc", flag_rdata, 8'h00);
        chk("R5 byte still held", data_rdata, 8'hD0);
        rd();

        // deferred overflow: holding buffer empty
        tx_load = 1; tick(); tx_done = 1; tick(); w1(8'h40);
        chk("R3 clean state", flag_rdata, 8'h20);
        rx(8'hE0); rx(8'hE1); rx(8'hE2);
        chk("R7 ovf deferred", flag_rdata, 8'hA0);
        wr_data(8'h11);
        chk("R7 still deferred", flag_rdata, 8'h80);
        tx_load = 1; tick();
        chk("R7 ovf at load", flag_rdata, 8'hA1);
        w1(8'h01);
        chk("R8 w1 clears ovf", flag_rdata, 8'hA0);
        chk("R6 third byte dropped", data_rdata, 8'hE0);
        rd(); chk("R6 second byte", data_rdata, 8'hE1);
        rd(); chk("R5 drained", flag_rdata, 8'h20);
        tx_done = 1; tick(); w1(8'h40);

        // slave select
        is_master = 1; ss_disable = 0; ss_n_pin = 0;
        tick(); tick();
        chk("R9 not before sync", flag_rdata, 8'h20);
        tick();
        chk("R9 ss set", flag_rdata, 8'h30);
        chk("R9 force pulse", {7'd0, force_slave}, 8'h01);
        tick();
        chk("R9 force one cycle", {7'd0, force_slave}, 8'h00);
        repeat (6) tick();
        w1(8'h10);
        repeat (5) tick();
        chk("R9 once per edge", flag_rdata, 8'h20);
        ss_n_pin = 1; repeat (4) tick();
        ss_disable = 1; ss_n_pin = 0; repeat (5) tick();
        chk("R9 disabled", flag_rdata, 8'h20);
        ss_n_pin = 1; ss_disable = 0; is_master = 0; repeat (4) tick();
        ss_n_pin = 0; repeat (5) tick();
        chk("R9 slave mode ignores", flag_rdata, 8'h20);
        ss_n_pin = 1; repeat (4) tick();

        // interrupt sweeps
        for (int e = 0; e < 256; e++) begin
            irq_en = 8'(e); tick(); tick();
            chk("R11 irq dre only", {7'd0, irq}, {7'd0, irq_en[5]});
        end
        irq_en = 0;
        wr_data(8'h22); tx_load = 1; tick(); tx_done = 1; tick();
        for (int e = 0; e < 256; e++) begin
            irq_en = 8'(e); tick(); tick();
            chk("R11 irq dre txc", {7'd0, irq}, {7'd0, |(irq_en & 8'h60)});
        end
        irq_en = 8'h40; tick(); tick();
        w1(8'h40);
        chk("R11 irq lags flag", {7'd0, irq}, 8'h01);
        tick();
        chk("R11 irq follows clear", {7'd0, irq}, 8'h00);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule